// File: doc/BRIEF.md
# Window Watchdog Timer

This block is a window watchdog for a processor subsystem. A free-running prescaler divides the bus clock by a fixed power of two, and then again by a programmable power of two. Each divided tick decrements a 7-bit down-counter. Software keeps the system alive by rewriting the counter before it sinks too far. The rewrite must also not come too early: while the counter is still above a programmable window value, a rewrite is itself treated as a fault.

Once armed, the watchdog cannot be disarmed except by a reset of the block. Either fault then produces a one-cycle system reset request. An early-warning flag is raised one step before the counter reaches the timeout point, so software gets a last chance to service the watchdog. The flag can be routed to an interrupt line.

Software reaches the block through a plain register port with a write strobe and a byte address. Reads are combinational. There are three registers:
- control at 0x0
- configuration at 0x4
- status at 0x8

Top module: `wdt_window_top`

## Requirements
- R1: After a synchronous reset, every register reads zero, and `rst_req` and `irq` are low.
- R2: Control bits 6:0 hold the counter, which software can read and write. It decrements once every 2^(PRE_LOG2+TB) bus clocks, where TB is configuration bits 13:11. It wraps from 0x00 to 0x7F.
- R3: Control bit 7 arms the watchdog. Writing 1 sets it. Writing 0 has no effect. Only a block reset clears it.
- R4: While armed, a decrement from 0x40 to 0x3F produces a one-cycle `rst_req` in the cycle after the counter changes. While not armed, the same decrement produces no request.
- R5: A control write produces `rst_req` if the watchdog was already armed before the write and the counter exceeds the window value. A counter equal to or below the window produces no request.
- R6: A control write that leaves the watchdog armed produces `rst_req` if it writes bit 6 as 0.
- R7: Status bit 0 is set when a decrement brings the counter to 0x40, whatever the interrupt enable holds. Writing 0 to it clears it. Writing 1 has no effect.
- R8: Configuration bit 9 enables the interrupt. Once set it stays set until reset. `irq` is high exactly when both the flag and the enable are set.
- R9: Any control write restarts the prescaler, so the next decrement comes a full period after the write.
- R10: The window value sits in configuration bits 6:0. All other bits, and any unmapped address, read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| rst_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | Early-warning interrupt |

## Verification
The decrement rate is checked at two timer bases by reading the counter one cycle before and one cycle after the expected step. This separates a correct divider from one that is off by a cycle or uses the wrong power. Refresh writes are placed with the counter exactly at the window value and one above it, which separates a correct compare from an inclusive one. The timeout is run both armed and unarmed. Writes of 0 and of 1 to the sticky bits and to the flag show which bits ignore which value. A second write in the middle of a prescaler period shows whether the divider restarts.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int CNT_W = 7;
    localparam int TB_W  = 3;
    localparam int DW    = 32;

    localparam logic [CNT_W-1:0] WARN_VAL   = CNT_W'(1) << (CNT_W - 1);
    localparam logic [CNT_W-1:0] PREWARN_VAL = WARN_VAL + CNT_W'(1);

    localparam int OFF_CTRL = 'h0;
    localparam int OFF_CFG  = 'h4;
    localparam int OFF_STAT = 'h8;

    localparam int CFG_EN_BIT = 9;
    localparam int CFG_TB_LSB = 11;
    localparam int CTRL_ARM_BIT = 7;

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] count;
    } ctrl_t;

    typedef struct packed {
        logic [TB_W-1:0]  tbase;
        logic             irq_en;
        logic [CNT_W-1:0] window;
    } cfg_t;

    function automatic logic [DW-1:0] ctrl_to_word(ctrl_t c);
        logic [DW-1:0] w;
        w = '0;
        w[CNT_W-1:0]      = c.count;
        w[CTRL_ARM_BIT]   = c.armed;
        return w;
    endfunction

    function automatic logic [DW-1:0] cfg_to_word(cfg_t c);
        logic [DW-1:0] w;
        w = '0;
        w[CNT_W-1:0]                   = c.window;
        w[CFG_EN_BIT]                  = c.irq_en;
        w[CFG_TB_LSB +: TB_W]          = c.tbase;
        return w;
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
#(
    parameter int PRE_LOG2 = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            restart,
    input  logic [TB_W-1:0] tbase,
    output logic            tick
);
    localparam int PW = PRE_LOG2 + (1 << TB_W) - 1;

    logic [PW-1:0] pcnt;
    logic [PW-1:0] last;

    always_comb begin
        last = (PW'(1) << (PRE_LOG2 + int'(tbase))) - PW'(1);
        tick = (pcnt == last) && !restart;
    end

    always_ff @(posedge clk) begin
        if (rst || restart || tick) pcnt <= '0;
        else                        pcnt <= pcnt + PW'(1);
    end

    // R9: a restart request leaves the divider at zero
    a_r9_restart_zero: assert property (@(posedge clk) disable iff (rst)
        restart |=> pcnt == '0);

endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             warn_evt,
    output logic             expire_evt
);
    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (load) count <= load_val;
        else if (tick) count <= count - CNT_W'(1);
    end

    always_comb begin
        warn_evt   = tick && !load && (count == PREWARN_VAL);
        expire_evt = tick && !load && (count == WARN_VAL);
    end

    // R2: one tick removes exactly one from the counter
    a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
        (tick && !load) |=> count == $past(count) - CNT_W'(1));

    // R2: with neither tick nor load the counter holds
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(count));

endmodule

// File: rtl/wdt_regfile.sv
module wdt_regfile
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]    wdata,
    input  logic [CNT_W-1:0] count,
    input  logic             warn_evt,
    output logic             ctrl_wr,
    output logic             armed,
    output cfg_t             cfg,
    output logic             flag,
    output logic [DW-1:0]    rdata
);
    logic sel_ctrl, sel_cfg, sel_stat;
    ctrl_t ctrl_view;

    always_comb begin
        sel_ctrl = (addr == ADDR_W'(OFF_CTRL));
        sel_cfg  = (addr == ADDR_W'(OFF_CFG));
        sel_stat = (addr == ADDR_W'(OFF_STAT));
        ctrl_wr  = wr_en && sel_ctrl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
        end else if (ctrl_wr && wdata[CTRL_ARM_BIT]) begin
            armed <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en && sel_cfg) begin
            cfg.window <= wdata[CNT_W-1:0];
            cfg.tbase  <= wdata[CFG_TB_LSB +: TB_W];
            cfg.irq_en <= cfg.irq_en | wdata[CFG_EN_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                                flag <= 1'b0;
        else if (warn_evt)                      flag <= 1'b1;
        else if (wr_en && sel_stat && !wdata[0]) flag <= 1'b0;
    end

    always_comb begin
        ctrl_view.armed = armed;
        ctrl_view.count = count;
        rdata = '0;
        if (sel_ctrl)      rdata = ctrl_to_word(ctrl_view);
        else if (sel_cfg)  rdata = cfg_to_word(cfg);
        else if (sel_stat) rdata = {{(DW-1){1'b0}}, flag};
    end

    // R3: arming is sticky
    a_r3_arm_sticky: assert property (@(posedge clk) disable iff (rst)
        armed |=> armed);

    // R8: interrupt enable is sticky
    a_r8_en_sticky: assert property (@(posedge clk) disable iff (rst)
        cfg.irq_en |=> cfg.irq_en);

    // R7: reaching the warning value always raises the flag
    a_r7_flag_set: assert property (@(posedge clk) disable iff (rst)
        warn_evt |=> flag);

endmodule

// File: rtl/wdt_window_top.sv
module wdt_window_top
    import wdt_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int PRE_LOG2 = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              rst_req,
    output logic              irq
);
    logic             tick;
    logic             ctrl_wr;
    logic             armed;
    logic             flag;
    logic             warn_evt;
    logic             expire_evt;
    logic [CNT_W-1:0] count;
    cfg_t             cfg;
    logic             fault_expire, fault_early, fault_low;
    logic             arm_after;

    wdt_prescaler #(.PRE_LOG2(PRE_LOG2)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (ctrl_wr),
        .tbase   (cfg.tbase),
        .tick    (tick)
    );

    wdt_downcount u_cnt (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .load       (ctrl_wr),
        .load_val   (wdata[CNT_W-1:0]),
        .count      (count),
        .warn_evt   (warn_evt),
        .expire_evt (expire_evt)
    );

    wdt_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .count    (count),
        .warn_evt (warn_evt),
        .ctrl_wr  (ctrl_wr),
        .armed    (armed),
        .cfg      (cfg),
        .flag     (flag),
        .rdata    (rdata)
    );

    always_comb begin
        arm_after    = armed | wdata[CTRL_ARM_BIT];
        fault_expire = armed && expire_evt;
        fault_early  = ctrl_wr && armed && (count > cfg.window);
        fault_low    = ctrl_wr && arm_after && !wdata[CNT_W-1];
        irq          = flag && cfg.irq_en;
    end

    always_ff @(posedge clk) begin
        if (rst) rst_req <= 1'b0;
        else     rst_req <= fault_expire | fault_early | fault_low;
    end

    // R4: armed expiry must raise a request
    a_r4_expire_req: assert property (@(posedge clk) disable iff (rst)
        (armed && expire_evt) |=> rst_req);

    // R4: unarmed and no write means no request
    a_r4_quiet: assert property (@(posedge clk) disable iff (rst)
        (!armed && !ctrl_wr) |=> !rst_req);

    // R6: arming write with bit 6 clear raises a request
    a_r6_low_write: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && wdata[CTRL_ARM_BIT] && !wdata[CNT_W-1]) |=> rst_req);

    // R8: interrupt never without flag
    a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        irq |-> u_regs.flag);

endmodule

// File: tb/wdt_window_top_tb_top.sv
module wdt_window_top_tb_top;
    localparam int ADDR_W = 10;
    localparam int PRE    = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              rst_req;
    logic              irq;

    int n_chk = 0;
    int n_bad = 0;
    int pulses = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wdt_window_top #(.ADDR_W(ADDR_W), .PRE_LOG2(PRE)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rst_req(rst_req), .irq(irq)
    );

    always @(negedge clk) if (rst_req) pulses++;

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; wr_en = 1'b0;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        wr('h0, 32'h0000_00C5);
        wr('h4, 32'h0000_3A7F);
        do_reset();
        rd('h0, v); chk("R1 ctrl after reset", v, 0);
        rd('h4, v); chk("R1 cfg after reset", v, 0);
        rd('h8, v); chk("R1 status after reset", v, 0);
        chk("R1 rst_req low", {31'b0, rst_req}, 0);
        chk("R1 irq low", {31'b0, irq}, 0);
    endtask

    task automatic t_rate();
        logic [31:0] v;
        do_reset();
        wr('h0, 32'h50);
        idle(7); rd('h0, v); chk("R2 base0 before step", v, 32'h50);
        idle(1); rd('h0, v); chk("R2 base0 after step", v, 32'h4F);
        wr('h4, 32'h1000);
        wr('h0, 32'h50);
        idle(31); rd('h0, v); chk("R2 base2 before step", v, 32'h50);
        idle(1);  rd('h0, v); chk("R2 base2 after step", v, 32'h4F);
        wr('h4, 32'h0);
        wr('h0, 32'h00);
        idle(8); rd('h0, v); chk("R2 wrap to 7F", v, 32'h7F);
    endtask

    task automatic t_restart();
        logic [31:0] v;
        do_reset();
        wr('h0, 32'h50);
        idle(5);
        wr('h0, 32'h50);
        idle(7); rd('h0, v); chk("R9 no step before full period", v, 32'h50);
        idle(1); rd('h0, v); chk("R9 step after full period", v, 32'h4F);
    endtask

    task automatic t_timeout();
        int p0;
        do_reset();
        p0 = pulses;
        wr('h0, 32'h41);
        idle(18);
        chk("R4 unarmed expiry silent", pulses - p0, 0);
        do_reset();
        p0 = pulses;
        wr('h0, 32'hC1);
        idle(15);
        chk("R4 no request before expiry", pulses - p0, 0);
        idle(3);
        chk("R4 single request on expiry", pulses - p0, 1);
    endtask

    task automatic t_arm();
        logic [31:0] v;
        do_reset();
        wr('h0, 32'hFF);
        rd('h0, v); chk("R3 armed after set", v[7], 1);
        wr('h0, 32'h7F);
        rd('h0, v); chk("R3 writing zero keeps arm", v[7], 1);
        do_reset();
        rd('h0, v); chk("R3 reset clears arm", v[7], 0);
    endtask

    task automatic t_window();
        int p0;
        do_reset();
        wr('h4, 32'h60);
        p0 = pulses;
        wr('h0, 32'hE0);
        idle(1);
        chk("R5 first arming write no request", pulses - p0, 0);
        wr('h0, 32'hE0);
        idle(1);
        chk("R5 count equal window no request", pulses - p0, 0);
        wr('h4, 32'h5F);
        wr('h0, 32'hE0);
        idle(1);
        chk("R5 count above window requests", pulses - p0, 1);
    endtask

    task automatic t_low_write();
        int p0;
        do_reset();
        p0 = pulses;
        wr('h0, 32'h3F);
        idle(1);
        chk("R6 unarmed low write silent", pulses - p0, 0);
        wr('h0, 32'hBF);
        idle(1);
        chk("R6 arming low write requests", pulses - p0, 1);
    endtask

    task automatic t_flag();
        logic [31:0] v;
        do_reset();
        wr('h0, 32'h41);
        idle(7); rd('h8, v); chk("R7 flag not yet set", v, 0);
        idle(2); rd('h8, v); chk("R7 flag set at 0x40", v, 1);
        chk("R8 irq low without enable", {31'b0, irq}, 0);
        wr('h8, 32'h1);
        rd('h8, v); chk("R7 write one keeps flag", v, 1);
        wr('h8, 32'h0);
        rd('h8, v); chk("R7 write zero clears flag", v, 0);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        do_reset();
        wr('h4, 32'h200);
        wr('h4, 32'h0);
        rd('h4, v); chk("R8 enable sticky", v, 32'h200);
        wr('h0, 32'h41);
        idle(9);
        chk("R8 irq with flag and enable", {31'b0, irq}, 1);
        wr('h8, 32'h0);
        chk("R8 irq drops with flag", {31'b0, irq}, 0);
    endtask

    task automatic t_readback();
        logic [31:0] v;
        do_reset();
        wr('h4, 32'hFFFF_FFFF);
        rd('h4, v); chk("R10 cfg unused bits zero", v, 32'h3A7F);
        wr('h4, 32'h0);
        wr('h0, 32'hFFFF_FF7F);
        rd('h0, v); chk("R10 ctrl unused bits zero", v, 32'h7F);
        wr('h8, 32'hFFFF_FFFF);
        rd('h8, v); chk("R10 status unused bits zero", v, 0);
        rd('hC, v); chk("R10 unmapped reads zero", v, 0);
    endtask

    initial begin
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        t_reset();
        t_rate();
        t_restart();
        t_timeout();
        t_arm();
        t_window();
        t_low_write();
        t_flag();
        t_irq();
        t_readback();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule